// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the slave side of a four-wire SPI (mode 0) link to a byte-addressed non-volatile store. The store is modelled here as an on-chip register array. A host drops chip select, shifts in a one-byte instruction most-significant bit first, and then sends address and data bytes or clocks out read data. The instruction set covers these operations: setting and clearing a write-enable latch, reading and writing a small status register, sequential reads that run through the whole array, and page writes of up to one page.

Programming is self-timed. A committed write is held in a page buffer and copied into the array while a busy flag is set for a fixed number of system clock cycles. During that period the host polls the status register to learn when the cycle has ended. Programming can be blocked in two ways: a write-protect pin, or a two-bit block code in the status register that protects the top quarter, the top half or the whole array. A hold input pauses the serial stream mid-transfer without losing its place.

All SPI pins are sampled by the system clock, which must run at least eight times faster than SCK, with each SCK phase lasting at least four system clocks. The array holds 2^ARRAY_AW bytes. A page holds 2^PAGE_AW bytes, and the busy period lasts the larger of PROG_CYCLES and one page.

Top module: `eep_spi_slave`

## Requirements
- R1: MOSI is sampled on SCK rising edges and MISO changes only after SCK falling edges. Every byte travels most-significant bit first, so a byte value of 0x80 and a byte value of 0x01 survive a write and read round trip unchanged.
- R2: The opcodes are 0x06 (set write-enable latch), 0x04 (clear it), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). The status byte holds busy in bit 0, the write-enable latch in bit 1 and the block code in bits 3:2, with the other bits zero. After reset the status byte is 0x00.
- R3: A read takes a two-byte address, high byte first, and only its low ARRAY_AW bits are used. Data then streams out with the address advancing by one after each byte and wrapping from the last byte of the array to byte 0.
- R4: miso_oe is low after reset, whenever chip select is high, and whenever the slave is not returning status or read data.
- R5: A write stores its data bytes starting at the given address. The low PAGE_AW address bits advance and wrap inside the same page, so a write starting two bytes before the end of a page continues at the start of that page.
- R6: A write or status write takes effect only if the write-enable latch was set when its opcode arrived, and only if chip select rises on a byte boundary after at least one complete data byte. An aborted or data-less write leaves the array, the latch and the busy flag unchanged.
- R7: From the commit until the timed cycle ends, status bit 0 reads 1. During that time every instruction except a status read is ignored, and a read issued then never drives miso_oe.
- R8: The write-enable latch clears when the programming cycle completes.
- R9: While hold_n is low, SCK edges are ignored and miso_oe is low. When hold_n returns high, the transfer continues from the same bit.
- R10: A status write stores data bits 3:2 as the block code. Code 00 protects nothing, 01 protects the upper quarter of the array, 10 the upper half and 11 all of it. Writes to protected bytes leave them unchanged, and the other bytes of the same write still program.
- R11: When wp_n is low as a write or status-write opcode arrives, that instruction is ignored.
- R12: Chip select rising ends an instruction. Any bytes after a completed one-byte instruction in the same selection are ignored, and the first byte after the next selection is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause of the serial stream |
| wp_n | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |

## Verification
The write path is tried with single bytes, with multi-byte writes that start near the end of a page, and with random start offsets and lengths. Page-relative wrapping is distinguished from a plain linear increment by reading back the whole page. Negative patterns each give an outcome that a correct block and a faulty one read back differently: writes without the latch, writes cut short mid-byte, writes with no data, writes under the protect pin, and writes under each block code. Reads are tried across the array end, with the unused high address bits set, and with a hold pause in the middle of a byte. Status polling during programming separates a block that ignores instructions while busy from one that answers them.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_READ,
        ST_WRITE,
        ST_SR_READ,
        ST_SR_WRITE,
        ST_SKIP
    } ctl_state_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] guard;
        logic       wel;
        logic       busy;
    } status_t;

    // top2 is the two most significant bits of the array address
    function automatic logic blk_locked(input logic [1:0] guard, input logic [1:0] top2);
        case (guard)
            2'b00:   blk_locked = 1'b0;
            2'b01:   blk_locked = (top2 == 2'b11);
            2'b10:   blk_locked = top2[1];
            default: blk_locked = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eep_spi_shift.sv
module eep_spi_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       hold_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_on,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       on_boundary,
    output logic       cs_rise,
    output logic       miso,
    output logic       miso_oe
);
    logic       sck_q;
    logic       cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       oe_arm;

    logic active;
    logic sck_rise;
    logic sck_fall;

    assign active      = !cs_n && hold_n;
    assign sck_rise    = active && sck && !sck_q;
    assign sck_fall    = active && !sck && sck_q;
    assign on_boundary = (bit_cnt == 3'd0);
    assign cs_rise     = cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            bit_cnt  <= 3'd0;
            rx_sh    <= 7'd0;
            tx_sh    <= 8'd0;
            oe_arm   <= 1'b0;
            miso     <= 1'b0;
            miso_oe  <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= 8'd0;
        end else begin
            sck_q    <= sck;
            cs_q     <= cs_n;
            rx_valid <= 1'b0;
            miso_oe  <= !cs_n && hold_n && oe_arm;
            if (cs_n) begin
                bit_cnt <= 3'd0;
                oe_arm  <= 1'b0;
            end else begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[5:0], mosi};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh, mosi};
                    end
                end
                if (sck_fall) begin
                    if (bit_cnt == 3'd0) begin
                        miso   <= tx_byte[7];
                        tx_sh  <= {tx_byte[6:0], 1'b0};
                        oe_arm <= tx_on;
                    end else begin
                        miso  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eep_cmd_ctl.sv
module eep_cmd_ctl
    import eep_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          cs_rise,
    input  logic          on_boundary,
    input  logic          wp_n,
    input  logic          busy,
    input  logic          prog_done,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_byte,
    output logic          tx_on,
    output logic [AW-1:0] rd_addr,
    output logic          pb_clear,
    output logic          pb_we,
    output logic [PW-1:0] pb_idx,
    output logic [7:0]    pb_data,
    output logic          prog_start,
    output logic          prog_sr,
    output logic [AW-PW-1:0] prog_page,
    output logic          wel,
    output logic [1:0]    guard
);
    localparam int HW = AW - 8;

    ctl_state_e    st;
    logic          is_write;
    logic [HW-1:0] addr_hi;
    logic [AW-1:0] addr;
    logic [PW-1:0] wptr;
    logic          got_data;
    logic [1:0]    sr_new;
    logic          sr_pend;
    status_t       sr;

    assign sr        = '{rsvd: 4'h0, guard: guard, wel: wel, busy: busy};
    assign tx_on     = (st == ST_READ) || (st == ST_SR_READ);
    assign tx_byte   = (st == ST_SR_READ) ? sr : rd_data;
    assign rd_addr   = addr;
    assign prog_page = addr[AW-1:PW];

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_OPCODE;
            is_write   <= 1'b0;
            addr_hi    <= '0;
            addr       <= '0;
            wptr       <= '0;
            got_data   <= 1'b0;
            sr_new     <= 2'b00;
            sr_pend    <= 1'b0;
            wel        <= 1'b0;
            guard      <= 2'b00;
            pb_clear   <= 1'b0;
            pb_we      <= 1'b0;
            pb_idx     <= '0;
            pb_data    <= 8'd0;
            prog_start <= 1'b0;
            prog_sr    <= 1'b0;
        end else begin
            pb_clear   <= 1'b0;
            pb_we      <= 1'b0;
            prog_start <= 1'b0;
            if (prog_done) begin
                wel <= 1'b0;
                if (sr_pend) begin
                    guard   <= sr_new;
                    sr_pend <= 1'b0;
                end
            end
            if (cs_rise) begin
                st       <= ST_OPCODE;
                got_data <= 1'b0;
                if ((st == ST_WRITE || st == ST_SR_WRITE) && got_data && on_boundary) begin
                    prog_start <= 1'b1;
                    prog_sr    <= (st == ST_SR_WRITE);
                    sr_pend    <= (st == ST_SR_WRITE);
                end
            end else if (rx_valid) begin
                case (st)
                    ST_OPCODE: begin
                        if (busy) begin
                            st <= (rx_byte == OP_RDSR) ? ST_SR_READ : ST_SKIP;
                        end else begin
                            case (rx_byte)
                                OP_WREN: begin
                                    wel <= 1'b1;
                                    st  <= ST_SKIP;
                                end
                                OP_WRDI: begin
                                    wel <= 1'b0;
                                    st  <= ST_SKIP;
                                end
                                OP_RDSR: st <= ST_SR_READ;
                                OP_WRSR: st <= (wel && wp_n) ? ST_SR_WRITE : ST_SKIP;
                                OP_READ: begin
                                    is_write <= 1'b0;
                                    st       <= ST_ADDR_HI;
                                end
                                OP_WRITE: begin
                                    if (wel && wp_n) begin
                                        is_write <= 1'b1;
                                        pb_clear <= 1'b1;
                                        st       <= ST_ADDR_HI;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                default: st <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR_HI: begin
                        addr_hi <= rx_byte[HW-1:0];
                        st      <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        addr <= {addr_hi, rx_byte};
                        wptr <= rx_byte[PW-1:0];
                        st   <= is_write ? ST_WRITE : ST_READ;
                    end
                    ST_READ: addr <= addr + 1'b1;
                    ST_WRITE: begin
                        pb_we    <= 1'b1;
                        pb_idx   <= wptr;
                        pb_data  <= rx_byte;
                        wptr     <= wptr + 1'b1;
                        got_data <= 1'b1;
                    end
                    ST_SR_WRITE: begin
                        sr_new   <= rx_byte[3:2];
                        got_data <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
    import eep_pkg::*;
#(
    parameter int AW          = 11,
    parameter int PW          = 5,
    parameter int PROG_CYCLES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pb_clear,
    input  logic             pb_we,
    input  logic [PW-1:0]    pb_idx,
    input  logic [7:0]       pb_data,
    input  logic             start,
    input  logic             start_sr,
    input  logic [AW-PW-1:0] page,
    input  logic [1:0]       guard,
    output logic             busy,
    output logic             done,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata
);
    localparam int PAGE = 1 << PW;
    localparam int RUN  = (PROG_CYCLES < PAGE) ? PAGE : PROG_CYCLES;
    localparam int CW   = $clog2(RUN + 1);

    logic [7:0]       pbuf [PAGE];
    logic [PAGE-1:0]  pmask;
    logic [CW-1:0]    remain;
    logic [PW:0]      step;
    logic [AW-PW-1:0] page_q;

    assign busy      = (remain != '0);
    assign done      = (remain == CW'(1));
    assign mem_addr  = {page_q, step[PW-1:0]};
    assign mem_wdata = pbuf[step[PW-1:0]];
    assign mem_we    = busy && !step[PW] && pmask[step[PW-1:0]]
                       && !blk_locked(guard, mem_addr[AW-1 -: 2]);

    generate
        for (genvar g = 0; g < PAGE; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst || pb_clear) begin
                    pbuf[g]  <= 8'd0;
                    pmask[g] <= 1'b0;
                end else if (pb_we && pb_idx == PW'(g)) begin
                    pbuf[g]  <= pb_data;
                    pmask[g] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            step   <= '0;
            page_q <= '0;
        end else if (start) begin
            remain <= RUN[CW-1:0];
            step   <= start_sr ? (PW+1)'(PAGE) : '0;
            page_q <= page;
        end else if (busy) begin
            remain <= remain - 1'b1;
            if (!step[PW]) step <= step + 1'b1;
        end
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
    parameter int ARRAY_AW    = 11,
    parameter int PAGE_AW     = 5,
    parameter int PROG_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);
    logic                     rx_valid;
    logic [7:0]               rx_byte;
    logic                     on_boundary;
    logic                     cs_rise;
    logic [7:0]               tx_byte;
    logic                     tx_on;
    logic [ARRAY_AW-1:0]      rd_addr;
    logic [7:0]               rd_data;
    logic                     pb_clear;
    logic                     pb_we;
    logic [PAGE_AW-1:0]       pb_idx;
    logic [7:0]               pb_data;
    logic                     prog_start;
    logic                     prog_sr;
    logic [ARRAY_AW-PAGE_AW-1:0] prog_page;
    logic                     wel;
    logic [1:0]               guard;
    logic                     busy;
    logic                     prog_done;
    logic                     mem_we;
    logic [ARRAY_AW-1:0]      mem_addr;
    logic [7:0]               mem_wdata;

    eep_spi_shift u_shift (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .hold_n(hold_n),
        .tx_byte(tx_byte), .tx_on(tx_on), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .on_boundary(on_boundary), .cs_rise(cs_rise), .miso(miso), .miso_oe(miso_oe)
    );

    eep_cmd_ctl #(.AW(ARRAY_AW), .PW(PAGE_AW)) u_ctl (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .on_boundary(on_boundary), .wp_n(wp_n), .busy(busy),
        .prog_done(prog_done), .rd_data(rd_data), .tx_byte(tx_byte), .tx_on(tx_on),
        .rd_addr(rd_addr), .pb_clear(pb_clear), .pb_we(pb_we), .pb_idx(pb_idx),
        .pb_data(pb_data), .prog_start(prog_start), .prog_sr(prog_sr),
        .prog_page(prog_page), .wel(wel), .guard(guard)
    );

    eep_prog_seq #(.AW(ARRAY_AW), .PW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst(rst), .pb_clear(pb_clear), .pb_we(pb_we), .pb_idx(pb_idx),
        .pb_data(pb_data), .start(prog_start), .start_sr(prog_sr), .page(prog_page),
        .guard(guard), .busy(busy), .done(prog_done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    eep_store #(.AW(ARRAY_AW)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/eep_spi_slave_chk.sv
module eep_spi_slave_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          hold_n,
    input logic          miso_oe,
    input logic          busy,
    input logic          wel,
    input logic          prog_start,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    guard
);
    a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !miso_oe);

    a_r9_oe_off_in_hold: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> !miso_oe);

    a_r7_array_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !busy);

    a_r6_start_needs_latch: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> wel);

    a_r8_latch_clears_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    a_r10_locked_block_untouched: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !eep_pkg::blk_locked(guard, mem_addr[AW-1 -: 2]));
endmodule

bind eep_spi_slave eep_spi_slave_chk #(.AW(ARRAY_AW)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .miso_oe(miso_oe),
    .busy(busy), .wel(wel), .prog_start(prog_start), .mem_we(mem_we),
    .mem_addr(mem_addr), .guard(guard)
);

// File: tb/eep_spi_slave_bench.sv
module eep_spi_slave_bench;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int PW    = 5;
    localparam int PROG  = 400;
    localparam int HALF  = 4;

    localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_RDSR = 8'h05,
                           C_WRSR = 8'h01, C_READ = 8'h03, C_WRITE = 8'h02;

    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic hold_n = 1'b1, wp_n = 1'b1;
    logic miso, miso_oe;

    eep_spi_slave #(.ARRAY_AW(AW), .PAGE_AW(PW), .PROG_CYCLES(PROG)) u_eep_spi_slave (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mdl   [DEPTH];
    bit         known [DEPTH];
    logic [1:0] guard_m = 2'b00;
    logic [7:0] wbuf [40];
    logic [7:0] rbuf [40];
    bit         oe_seen = 1'b0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_locked(input logic [1:0] g, input int a);
        case (g)
            2'b00:   return 1'b0;
            2'b01:   return a >= (DEPTH * 3) / 4;
            2'b10:   return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            if (miso_oe) oe_seen = 1'b1;
        end
    endtask

    task automatic spi_bit(input logic b, output logic r);
        mosi = b;
        tick(HALF - 1);
        r = miso;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
        tick(1);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            spi_bit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic cs_hi();
        tick(2);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] d;
        cs_lo();
        spi_byte(op, d);
        cs_hi();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        cs_lo();
        spi_byte(C_RDSR, d);
        spi_byte(8'h00, s);
        cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 40 && s[0]; k++) rd_status(s);
        chk(s[0], 1'b0, "R7 busy ends after timed cycle");
    endtask

    task automatic wr_page(input logic [15:0] a, input int n, input bit wren);
        logic [7:0] d;
        if (wren) send_op(C_WREN);
        cs_lo();
        spi_byte(C_WRITE, d);
        spi_byte(a[15:8], d);
        spi_byte(a[7:0], d);
        for (int i = 0; i < n; i++) spi_byte(wbuf[i], d);
        cs_hi();
    endtask

    task automatic model_page(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            int x;
            x = (a & ~31) | ((a + i) & 31);
            if (!exp_locked(guard_m, x)) begin
                mdl[x]   = wbuf[i];
                known[x] = 1'b1;
            end
        end
    endtask

    task automatic rd_seq(input logic [15:0] a, input int n);
        logic [7:0] d;
        cs_lo();
        spi_byte(C_READ, d);
        spi_byte(a[15:8], d);
        spi_byte(a[7:0], d);
        for (int i = 0; i < n; i++) spi_byte(8'h00, rbuf[i]);
        cs_hi();
    endtask

    task automatic chk_range(input int base, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int x;
            x = (base + i) % DEPTH;
            if (known[x]) chk(rbuf[i], mdl[x], tag);
        end
    endtask

    task automatic set_guard(input logic [1:0] g);
        logic [7:0] d;
        send_op(C_WREN);
        cs_lo();
        spi_byte(C_WRSR, d);
        spi_byte({4'h0, g, 2'b00}, d);
        cs_hi();
        wait_idle();
        guard_m = g;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int unused_seed;
        unused_seed = $urandom(32'h2c41);
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        tick(2);

        // reset state
        chk(miso_oe, 1'b0, "R4 output disabled after reset");
        rd_status(s);
        chk(s, 8'h00, "R2 status after reset");

        // latch set and clear
        send_op(C_WREN);
        rd_status(s);
        chk(s, 8'h02, "R2 write-enable latch set");
        send_op(C_WRDI);
        rd_status(s);
        chk(s, 8'h00, "R2 write-enable latch cleared");

        // page write starting two bytes before page end
        wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hA5; wbuf[3] = 8'h3C;
        wr_page(16'd126, 4, 1'b1);
        model_page(126, 4);
        rd_status(s);
        chk(s, 8'h03, "R7 busy and latch visible while programming");
        oe_seen = 1'b0;
        rd_seq(16'd126, 2);
        chk(oe_seen, 1'b0, "R7 read ignored while busy");
        wait_idle();
        rd_status(s);
        chk(s, 8'h00, "R8 latch cleared after programming");
        rd_seq(16'd96, 32);
        chk(rbuf[30], 8'h80, "R1 msb-first byte 0x80");
        chk(rbuf[31], 8'h01, "R1 msb-first byte 0x01");
        chk_range(96, 32, "R5 page-relative wrap");

        // write without latch
        wbuf[0] = 8'h77;
        wr_page(16'd126, 1, 1'b0);
        rd_status(s);
        chk(s, 8'h00, "R6 write without latch not started");
        rd_seq(16'd126, 1);
        chk(rbuf[0], 8'h80, "R6 write without latch ignored");

        // write cut short mid-byte
        send_op(C_WREN);
        cs_lo();
        spi_byte(C_WRITE, d); spi_byte(8'h00, d); spi_byte(8'd126, d);
        spi_byte(8'h55, d);
        for (int i = 0; i < 3; i++) begin
            logic b;
            spi_bit(1'b1, b);
        end
        cs_hi();
        rd_status(s);
        chk(s, 8'h02, "R6 partial byte does not commit");
        rd_seq(16'd126, 1);
        chk(rbuf[0], 8'h80, "R6 partial byte leaves array");

        // write with address but no data
        cs_lo();
        spi_byte(C_WRITE, d); spi_byte(8'h00, d); spi_byte(8'd126, d);
        cs_hi();
        rd_status(s);
        chk(s, 8'h02, "R6 data-less write does not commit");
        send_op(C_WRDI);

        // protect pin
        wp_n = 1'b0;
        wbuf[0] = 8'h66;
        wr_page(16'd126, 1, 1'b1);
        rd_status(s);
        chk(s, 8'h02, "R11 write ignored under protect pin");
        cs_lo();
        spi_byte(C_WRSR, d); spi_byte(8'h0C, d);
        cs_hi();
        rd_status(s);
        chk(s, 8'h02, "R11 status write ignored under protect pin");
        wp_n = 1'b1;
        rd_seq(16'd126, 1);
        chk(rbuf[0], 8'h80, "R11 array unchanged under protect pin");
        send_op(C_WRDI);

        // block codes
        wbuf[0] = 8'hE1; wr_page(16'd1600, 1, 1'b1); model_page(1600, 1); wait_idle();
        wbuf[0] = 8'hD2; wr_page(16'd1100, 1, 1'b1); model_page(1100, 1); wait_idle();
        wbuf[0] = 8'hC3; wr_page(16'd100, 1, 1'b1);  model_page(100, 1);  wait_idle();
        set_guard(2'b01);
        rd_status(s);
        chk(s, 8'h04, "R10 block code stored");
        wbuf[0] = 8'h11; wr_page(16'd1600, 1, 1'b1); model_page(1600, 1); wait_idle();
        wbuf[0] = 8'h12; wr_page(16'd100, 1, 1'b1);  model_page(100, 1);  wait_idle();
        set_guard(2'b10);
        wbuf[0] = 8'h13; wr_page(16'd1100, 1, 1'b1); model_page(1100, 1); wait_idle();
        set_guard(2'b11);
        wbuf[0] = 8'h15; wr_page(16'd100, 1, 1'b1);  model_page(100, 1);  wait_idle();
        rd_status(s);
        chk(s, 8'h0C, "R10 whole-array code stored");
        set_guard(2'b00);
        rd_seq(16'd1600, 1); chk(rbuf[0], 8'hE1, "R10 upper quarter protected");
        rd_seq(16'd1100, 1); chk(rbuf[0], 8'hD2, "R10 upper half protected");
        rd_seq(16'd100, 1);  chk(rbuf[0], 8'h12, "R10 lower quarter writable then locked");

        // hold in the middle of a read byte
        cs_lo();
        spi_byte(C_READ, d); spi_byte(8'h00, d); spi_byte(8'd126, d);
        for (int i = 7; i >= 5; i--) begin
            logic b;
            spi_bit(1'b0, b);
            rbuf[0][i] = b;
        end
        hold_n = 1'b0;
        tick(3);
        chk(miso_oe, 1'b0, "R9 output disabled in hold");
        repeat (2) begin
            sck = 1'b1; tick(HALF);
            sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1;
        tick(3);
        for (int i = 4; i >= 0; i--) begin
            logic b;
            spi_bit(1'b0, b);
            rbuf[0][i] = b;
        end
        spi_byte(8'h00, rbuf[1]);
        cs_hi();
        chk(rbuf[0], 8'h80, "R9 byte intact across hold");
        chk(rbuf[1], 8'h01, "R9 stream resumes after hold");

        // sequential read over the array end, and ignored high address bits
        wbuf[0] = 8'h9A; wbuf[1] = 8'h5B;
        wr_page(16'(DEPTH - 2), 2, 1'b1); model_page(DEPTH - 2, 2); wait_idle();
        wbuf[0] = 8'h4C; wbuf[1] = 8'h2D;
        wr_page(16'd0, 2, 1'b1); model_page(0, 2); wait_idle();
        rd_seq(16'(DEPTH - 2), 4);
        chk_range(DEPTH - 2, 4, "R3 sequential read wraps at array end");
        rd_seq(16'hF800 | 16'(DEPTH - 2), 1);
        chk(rbuf[0], 8'h9A, "R3 upper address bits ignored");

        // extra bytes after a one-byte instruction
        oe_seen = 1'b0;
        cs_lo();
        spi_byte(C_WREN, d); spi_byte(C_RDSR, d); spi_byte(8'h00, d);
        cs_hi();
        chk(oe_seen, 1'b0, "R12 trailing bytes not decoded");
        rd_status(s);
        chk(s, 8'h02, "R12 next selection decodes opcode");
        send_op(C_WRDI);

        // random page writes
        for (int it = 0; it < 16; it++) begin
            int a, n;
            a = int'($urandom % DEPTH);
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_page(16'(a), n, 1'b1);
            model_page(a, n);
            wait_idle();
            rd_status(s);
            chk(s, 8'h00, "R8 latch cleared after random write");
            rd_seq(16'(a & ~31), 32);
            chk_range(a & ~31, 32, "R5 random page write readback");
        end

        summary();
        $finish;
    end
endmodule